// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

The block is a chain of 4-bit presettable binary counter stages. Every state change happens on the rising clock edge. A synchronous active-low load copies a parallel data word into the count. Two active-low enables gate counting: a parallel enable goes to all stages, and a trickle enable feeds the first stage only. A direction input selects counting up or counting down.

Each stage drives an active-low carry. The carry goes low combinationally when the stage's trickle enable is low and the stage sits at its terminal value. That value is all ones when counting up and zero when counting down. The carry of one stage is wired straight to the trickle enable of the next, so the chain behaves as one wide synchronous counter with no added gating. The last stage's carry is brought out so that chains can be joined in turn.

The number of stages is a parameter. The default chain is three stages, giving 12 bits. A single-stage chain is the plain 4-bit counter. An active-low asynchronous reset clears the count.

Top module: `updn_counter_chain`

## Requirements
- R1: While rst_ni is low, count_o is zero.
- R2: When load_ni is low at a rising edge, count_o takes data_i after that edge, whatever the levels of en_par_ni, en_trk_ni and up_i.
- R3: With load_ni high, en_par_ni low, en_trk_ni low and up_i high, the count rises by one at each edge, and all ones wraps to zero.
- R4: With load_ni high, both enables low and up_i low, the count falls by one at each edge, and zero wraps to all ones.
- R5: With load_ni high and either en_par_ni or en_trk_ni high, the count holds across the edge.
- R6: carry_no is low exactly when en_trk_ni is low and the count is at its terminal value: all ones with up_i high, zero with up_i low. carry_no ignores en_par_ni and follows en_trk_ni and up_i between edges, with no clock edge needed.
- R7: Each stage's carry drives the next stage's trickle enable, so the whole chain counts modulo 2^(4*NUM_STAGES) as one counter. Data bit 0 is the least significant bit of the lowest stage.
- R8: Changes on the control and data inputs between edges leave count_o unchanged until the next rising edge.
- R9: A 4-bit stage loaded with 13 counts up through 14, 15, 0, 1, 2 and holds while the enables are high. It then counts down through 1, 0, 15, 14, 13. carry_no is low at 15 going up and at 0 going down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the count |
| load_ni | input | 1 | Synchronous parallel load, active low; takes priority |
| en_par_ni | input | 1 | Parallel count enable to all stages, active low |
| en_trk_ni | input | 1 | Trickle count enable into the lowest stage, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| data_i | input | 4*NUM_STAGES | Parallel load value |
| count_o | output | 4*NUM_STAGES | Current count |
| carry_no | output | 1 | Carry from the top stage, active low |

## Verification
The bench aims at the edges of the count range: all ones to zero going up, zero to all ones going down, and ripples that cross stage boundaries such as 0x0FF to 0x100. A chain that forwards the carry wrongly stalls or skips its upper nibbles there. It checks the carry with the parallel enable high and after a direction change, where a carry gated by the wrong enable or stored in a flop would be wrong. It loads with the enables asserted, which exposes a design where counting wins over loading. It also runs the classic load, count up, hold, count down sequence on a single stage, followed by long random runs compared against a modular-arithmetic model.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int unsigned STAGE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_LOAD,
    OP_UP,
    OP_DOWN
  } cnt_op_e;
endpackage

// File: rtl/updn_next_state.sv
module updn_next_state
  import updn_pkg::*;
#(
  parameter int unsigned W = STAGE_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  input  logic         load_ni,
  input  logic         en_par_ni,
  input  logic         en_trk_ni,
  input  logic         up_i,
  output logic [W-1:0] next_o
);
  cnt_op_e op;

  // load wins over counting
  always_comb begin
    if (!load_ni)                    op = OP_LOAD;
    else if (!en_par_ni && !en_trk_ni) op = up_i ? OP_UP : OP_DOWN;
    else                             op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD: next_o = data_i;
      OP_UP:   next_o = cur_i + W'(1);
      OP_DOWN: next_o = cur_i - W'(1);
      default: next_o = cur_i;
    endcase
  end
endmodule

// File: rtl/updn_terminal_detect.sv
module updn_terminal_detect
  import updn_pkg::*;
#(
  parameter int unsigned W = STAGE_W
) (
  input  logic [W-1:0] cur_i,
  input  logic         up_i,
  input  logic         en_trk_ni,
  output logic         carry_no
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  logic at_term;

  always_comb begin
    at_term  = up_i ? (cur_i == TOP) : (cur_i == BOT);
    carry_no = ~(~en_trk_ni & at_term);
  end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
#(
  parameter int unsigned W = STAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic         en_par_ni,
  input  logic         en_trk_ni,
  input  logic         up_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         carry_no
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  updn_next_state #(.W(W)) i_next (
    .cur_i     (cnt_q),
    .data_i    (data_i),
    .load_ni   (load_ni),
    .en_par_ni (en_par_ni),
    .en_trk_ni (en_trk_ni),
    .up_i      (up_i),
    .next_o    (cnt_d)
  );

  updn_terminal_detect #(.W(W)) i_term (
    .cur_i     (cnt_q),
    .up_i      (up_i),
    .en_trk_ni (en_trk_ni),
    .carry_no  (carry_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i)); // R2
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_par_ni && !en_trk_ni && up_i) |=> count_o == W'($past(count_o) + W'(1))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_par_ni && !en_trk_ni && !up_i) |=> count_o == W'($past(count_o) - W'(1))); // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (en_par_ni || en_trk_ni)) |=> $stable(count_o)); // R5
  AST_CARRY_NEEDS_TRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> !en_trk_ni); // R6
endmodule

// File: rtl/updn_counter_chain.sv
module updn_counter_chain
  import updn_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_ni,
  input  logic                            en_par_ni,
  input  logic                            en_trk_ni,
  input  logic                            up_i,
  input  logic [NUM_STAGES*STAGE_W-1:0]   data_i,
  output logic [NUM_STAGES*STAGE_W-1:0]   count_o,
  output logic                            carry_no
);
  localparam int unsigned TOTAL_W = NUM_STAGES * STAGE_W;
  localparam logic [TOTAL_W-1:0] ALL_ONES = '1;

  // trk_n[k] is the trickle enable of stage k; trk_n[NUM_STAGES] is the chain carry
  logic [NUM_STAGES:0] trk_n;
  assign trk_n[0] = en_trk_ni;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    updn_stage #(.W(STAGE_W)) i_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_ni   (load_ni),
      .en_par_ni (en_par_ni),
      .en_trk_ni (trk_n[g]),
      .up_i      (up_i),
      .data_i    (data_i[g*STAGE_W +: STAGE_W]),
      .count_o   (count_o[g*STAGE_W +: STAGE_W]),
      .carry_no  (trk_n[g+1])
    );
  end

  assign carry_no = trk_n[NUM_STAGES];

  AST_CHAIN_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_par_ni && !en_trk_ni && up_i) |=> count_o == TOTAL_W'($past(count_o) + TOTAL_W'(1))); // R7
  AST_CHAIN_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_par_ni && !en_trk_ni && !up_i) |=> count_o == TOTAL_W'($past(count_o) - TOTAL_W'(1))); // R7
  AST_CHAIN_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (count_o == (up_i ? ALL_ONES : '0))); // R6
endmodule

// File: tb/test_updn_counter_chain.sv
`timescale 1ns/1ps
module test_updn_counter_chain;
  localparam int unsigned N = 3;
  localparam int unsigned TW = 4 * N;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_ni = 1'b1, en_par_ni = 1'b1, en_trk_ni = 1'b1, up_i = 1'b1;
  logic [TW-1:0] data_i = '0;
  logic [TW-1:0] count_o;
  logic          carry_no;
  logic [3:0]    cnt4;
  logic          carry4_n;

  always #4 clk_i = ~clk_i;

  updn_counter_chain #(.NUM_STAGES(N)) i_updn_counter_chain (
    .clk_i, .rst_ni, .load_ni, .en_par_ni, .en_trk_ni, .up_i,
    .data_i, .count_o, .carry_no
  );

  updn_counter_chain #(.NUM_STAGES(1)) i_updn_counter_chain_single (
    .clk_i, .rst_ni, .load_ni, .en_par_ni, .en_trk_ni, .up_i,
    .data_i (data_i[3:0]), .count_o (cnt4), .carry_no (carry4_n)
  );

  typedef struct {
    logic [TW-1:0] c12;
    logic [3:0]    c4;
    string         tag;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [TW-1:0] m12 = '0;
  logic [3:0]    m4 = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: apply inputs, check combinational carry and count stability, push expected next count
  task automatic step(input logic ld_n, input logic ep_n, input logic et_n, input logic dir,
                      input logic [TW-1:0] d, input string tag);
    exp_t it;
    logic exp_c12, exp_c4;
    @(negedge clk_i);
    load_ni = ld_n; en_par_ni = ep_n; en_trk_ni = et_n; up_i = dir; data_i = d;
    #1;
    check(count_o == m12, "R8", 32'(count_o), 32'(m12));
    check(cnt4 == m4, "R8", 32'(cnt4), 32'(m4));
    exp_c12 = !(!et_n && (dir ? (m12 == '1) : (m12 == '0)));
    exp_c4  = !(!et_n && (dir ? (m4 == 4'hF) : (m4 == 4'h0)));
    check(carry_no == exp_c12, {"R6/", tag}, 32'(carry_no), 32'(exp_c12));
    check(carry4_n == exp_c4, {"R6/", tag}, 32'(carry4_n), 32'(exp_c4));
    if (!ld_n) begin
      m12 = d; m4 = d[3:0];
    end else if (!ep_n && !et_n) begin
      m12 = dir ? m12 + 1'b1 : m12 - 1'b1;
      m4  = dir ? m4 + 1'b1 : m4 - 1'b1;
    end
    it.c12 = m12; it.c4 = m4; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare registered outputs after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(count_o == it.c12, it.tag, 32'(count_o), 32'(it.c12));
        check(cnt4 == it.c4, it.tag, 32'(cnt4), 32'(it.c4));
      end
    end
  end

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(count_o == '0, "R1", 32'(count_o), 32'd0);
    check(cnt4 == 4'h0, "R1", 32'(cnt4), 32'd0);
    rst_ni = 1'b1;

    // R2: load wins with enables active and direction down
    step(1'b0, 1'b0, 1'b0, 1'b0, 12'h5A3, "R2");
    step(1'b0, 1'b1, 1'b0, 1'b1, 12'h3C7, "R2");

    // R5: either enable high holds
    step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b0, 12'hFFF, "R5");

    // R3 / R7: up wrap of the full chain and of one stage
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFE, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R7");

    // R4: down wrap
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h001, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R4");

    // R7: ripples across stage boundaries
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h0FF, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R7");

    // R6: carry ignores parallel enable, tracks direction and trickle enable
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFF, "R2");
    step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h000, "R2");
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R6");

    // R9: load 13, up five, hold, down five
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFD, "R9");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R9");
    check(m4 == 4'h2, "R9", 32'(m4), 32'h2);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R9");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R9");
    check(m4 == 4'hD, "R9", 32'(m4), 32'hD);

    // R7: random cascade stimulus
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step((r[0] | r[1] | r[2]), ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
           r[3], 12'($urandom), "R7");
    end

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule